// File: doc/BRIEF.md
# SuperSpeed Port Compliance-Entry Controller

This block sits beside one SuperSpeed root or device port and decides whether the link may drop into the Compliance substate when a Polling handshake times out. It watches the software writes aimed at the port's status and control word and pulls out four things: the requested link value, the port-power bit, the link-write strobe and the warm-reset bit. From those it keeps a hidden per-port arm flag. Hardware reset, the host-controller reset input and a warm port reset all clear it.

The controller drives a reduced link-state output with three values: RxDetect, Polling and Compliance. It also gives a one-cycle pulse on the cycle the link enters Compliance.

- **Host mode, capability input high:** software must arm the port while nothing is attached.
- **Host mode, capability input low:** every Polling timeout enters Compliance.
- **Device mode:** only the first Polling timeout after power-on may enter.

Both outputs are registered.

Top module: `ss_cmpl_entry_ctl`

## Requirements
- R1: While `rst_n` is low, `link_state_o` reads 0x5 (RxDetect) and `cmpl_enter_o` reads 0. Reset also clears the arm flag and restores the device-mode first-failure allowance.
- R2: A write word carries four fields. Bits 8:5 hold the link value, bit 9 is port power, bit 16 is the link-write strobe and bit 31 is warm reset. The arm flag is set by a write with link value 0xA, strobe 1 and power 1, made while the port is disconnected. Disconnected means the link is in RxDetect and `attach_i` is low in that same cycle.
- R3: A write with the strobe at 0, or power at 0, or a link value other than 0xA, or made while attached, leaves the arm flag unchanged. Writes without the warm-reset bit never change `link_state_o`.
- R4: From RxDetect, `attach_i` high moves the link to Polling (0x7) at the next edge. In Polling, `attach_i` low with no timeout returns it to RxDetect.
- R5: In host mode with `sw_arm_cap_i`=1, `lfps_tmo_i` during Polling has two outcomes. If the port is armed, the link moves to Compliance (0xA) and `cmpl_enter_o` is high for exactly that one cycle. If it is not armed, the link returns to RxDetect and no pulse is given.
- R6: In host mode with `sw_arm_cap_i`=0, every Polling timeout enters Compliance and the arm flag is ignored.
- R7: In device mode (`host_mode_i`=0), only the first Polling timeout since `rst_n` enters Compliance. Every later timeout returns the link to RxDetect, whatever the arm flag and the capability input hold, and a host-controller reset does not restore the allowance.
- R8: A write with bit 31 set moves the link to RxDetect at the next edge from any state and clears the arm flag. It wins over a timeout in the same cycle and over arming fields in the same word, so software must re-arm after leaving Compliance.
- R9: `host_rst_i` high moves the link to RxDetect at the next edge and clears the arm flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| host_rst_i | input | 1 | Host-controller reset request |
| wr_en_i | input | 1 | Write to the port status/control word |
| wr_data_i | input | REG_W | Write data |
| attach_i | input | 1 | Partner attached (level) |
| lfps_tmo_i | input | 1 | Polling handshake timeout pulse |
| host_mode_i | input | 1 | 1 = host behaviour, 0 = device behaviour |
| sw_arm_cap_i | input | 1 | 1 = entry must be armed by software (static) |
| link_state_o | output | 4 | Link state: 0x5 RxDetect, 0x7 Polling, 0xA Compliance |
| cmpl_enter_o | output | 1 | One-cycle pulse on Compliance entry |

## Verification
The arming write and the attach indication can arrive in the same cycle. The bench drives `attach_i` high on the very edge that carries an otherwise valid arming word, then looks at the outcome of the next timeout. A rejected arm shows up as a return to RxDetect rather than Compliance.

A warm-reset write can also coincide with a Polling timeout. The bench drives both together and expects RxDetect with no entry pulse. The next timeout is then used to show that the arm flag was cleared.

A sweep over capability, link value, power, strobe and attach timing compares each entry outcome with an arithmetic expectation.

// File: rtl/cmpl_entry_pkg.sv
package cmpl_entry_pkg;
   localparam int LS_W = 4;

   typedef enum logic [LS_W-1:0] {
      LNK_RXDET = 4'h5,
      LNK_POLL  = 4'h7,
      LNK_CMPL  = 4'hA
   } link_e;

   localparam logic [LS_W-1:0] ARM_CODE = 4'hA;
endpackage

// File: rtl/cmpl_wr_decode.sv
module cmpl_wr_decode
   import cmpl_entry_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int LS_LSB   = 5,
   parameter int PWR_BIT  = 9,
   parameter int STB_BIT  = 16,
   parameter int WRST_BIT = 31
) (
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic             arm_req_o,
   output logic             warm_req_o
);
   localparam int LS_MSB = LS_LSB + LS_W - 1;

   initial begin
      assert (LS_MSB < REG_W) else $error("link field outside word");
      assert (PWR_BIT < REG_W && STB_BIT < REG_W && WRST_BIT < REG_W)
         else $error("control bit outside word");
      assert (PWR_BIT != STB_BIT && PWR_BIT != WRST_BIT && STB_BIT != WRST_BIT)
         else $error("control bits overlap");
   end

   logic [LS_W-1:0] ls_field;
   logic            pwr, stb, wrst;
   logic            unused_wr;

   assign ls_field   = wr_data_i[LS_MSB:LS_LSB];
   assign pwr        = wr_data_i[PWR_BIT];
   assign stb        = wr_data_i[STB_BIT];
   assign wrst       = wr_data_i[WRST_BIT];
   assign unused_wr  = ^wr_data_i;

   // R2: arming request needs strobe, power and the Compliance code
   assign arm_req_o  = wr_en_i && stb && pwr && (ls_field == ARM_CODE);
   assign warm_req_o = wr_en_i && wrst;
endmodule

// File: rtl/cmpl_arm_flag.sv
module cmpl_arm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic arm_req_i,
   input  logic disc_i,
   output logic arm_o
);
   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  arm_q <= 1'b0;
      else if (clr_i)              arm_q <= 1'b0;   // R8/R9 clearing wins
      else if (arm_req_i && disc_i) arm_q <= 1'b1;
   end

   assign arm_o = arm_q;

   a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !arm_q);
   a_r3_reject_attached: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_req_i && !disc_i && !arm_q) |=> !arm_q);
   a_r2_set_disc: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_req_i && disc_i && !clr_i) |=> arm_q);
endmodule

// File: rtl/cmpl_entry_gate.sv
module cmpl_entry_gate #(
   parameter bit DEV_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic host_mode_i,
   input  logic sw_arm_cap_i,
   input  logic arm_i,
   input  logic tmo_act_i,
   output logic entry_ok_o
);
   logic host_ok;

   // R5/R6: armed entry only when software control is advertised
   assign host_ok = sw_arm_cap_i ? arm_i : 1'b1;

   generate
      if (DEV_SUPPORT) begin : g_dev
         logic used_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         used_q <= 1'b0;
            else if (tmo_act_i && !host_mode_i) used_q <= 1'b1;
         end

         // R7: device mode allows only the first failure after power-on
         assign entry_ok_o = host_mode_i ? host_ok : !used_q;

         a_r7_consume: assert property (@(posedge clk) disable iff (!rst_n)
            (tmo_act_i && !host_mode_i) |=> used_q);
         a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            used_q |=> used_q);
      end else begin : g_host_only
         logic unused_dev;
         assign unused_dev = tmo_act_i ^ host_mode_i;
         assign entry_ok_o = host_ok;
      end
   endgenerate
endmodule

// File: rtl/ss_cmpl_entry_ctl.sv
module ss_cmpl_entry_ctl
   import cmpl_entry_pkg::*;
#(
   parameter int REG_W       = 32,
   parameter int LS_LSB      = 5,
   parameter int PWR_BIT     = 9,
   parameter int STB_BIT     = 16,
   parameter int WRST_BIT    = 31,
   parameter bit DEV_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_rst_i,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             attach_i,
   input  logic             lfps_tmo_i,
   input  logic             host_mode_i,
   input  logic             sw_arm_cap_i,
   output logic [LS_W-1:0]  link_state_o,
   output logic             cmpl_enter_o
);
   link_e link_q;
   logic  pulse_q;
   logic  arm_req, warm_req, arm, disc, tmo_act, entry_ok, clr;

   cmpl_wr_decode #(
      .REG_W(REG_W), .LS_LSB(LS_LSB), .PWR_BIT(PWR_BIT),
      .STB_BIT(STB_BIT), .WRST_BIT(WRST_BIT)
   ) u_dec (
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .arm_req_o (arm_req),
      .warm_req_o(warm_req)
   );

   assign disc = (link_q == LNK_RXDET) && !attach_i;
   assign clr  = host_rst_i || warm_req;

   cmpl_arm_flag u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr),
      .arm_req_i(arm_req),
      .disc_i   (disc),
      .arm_o    (arm)
   );

   assign tmo_act = (link_q == LNK_POLL) && lfps_tmo_i && !clr;

   cmpl_entry_gate #(.DEV_SUPPORT(DEV_SUPPORT)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_mode_i (host_mode_i),
      .sw_arm_cap_i(sw_arm_cap_i),
      .arm_i       (arm),
      .tmo_act_i   (tmo_act),
      .entry_ok_o  (entry_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q  <= LNK_RXDET;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (clr) begin
            link_q <= LNK_RXDET;                 // R8/R9
         end else begin
            unique case (link_q)
               LNK_RXDET: if (attach_i) link_q <= LNK_POLL;
               LNK_POLL: begin
                  if (lfps_tmo_i) begin
                     if (entry_ok) begin
                        link_q  <= LNK_CMPL;
                        pulse_q <= 1'b1;
                     end else begin
                        link_q  <= LNK_RXDET;
                     end
                  end else if (!attach_i) begin
                     link_q <= LNK_RXDET;
                  end
               end
               LNK_CMPL: link_q <= LNK_CMPL;
               default:  link_q <= LNK_RXDET;
            endcase
         end
      end
   end

   assign link_state_o = link_q;
   assign cmpl_enter_o = pulse_q;

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_enter_o |=> !cmpl_enter_o);
   a_r5_entry_from_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (link_q == LNK_POLL && lfps_tmo_i && !clr && entry_ok)
         |=> (link_state_o == 4'hA && cmpl_enter_o));
   a_r8_warm_exit: assert property (@(posedge clk) disable iff (!rst_n)
      warm_req |=> (link_state_o == 4'h5 && !cmpl_enter_o));
   a_r9_host_reset: assert property (@(posedge clk) disable iff (!rst_n)
      host_rst_i |=> (link_state_o == 4'h5));
   a_r3_write_keeps_link: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !clr && disc) |=> (link_state_o == 4'h5));
endmodule

// File: tb/ss_cmpl_entry_ctl_tb.sv
module ss_cmpl_entry_ctl_tb;
   localparam logic [3:0] RX = 4'h5, PL = 4'h7, CP = 4'hA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0, host_rst = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        attach = 1'b0, lfps = 1'b0, host_mode = 1'b1, cap = 1'b1;
   logic [3:0]  link;
   logic        pulse;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   ss_cmpl_entry_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .host_rst_i(host_rst), .wr_en_i(wr_en),
      .wr_data_i(wr_data), .attach_i(attach), .lfps_tmo_i(lfps),
      .host_mode_i(host_mode), .sw_arm_cap_i(cap),
      .link_state_o(link), .cmpl_enter_o(pulse)
   );

   function automatic logic [31:0] mk(input logic [3:0] ls, input logic p,
                                      input logic s, input logic w);
      logic [31:0] d = '0;
      d[8:5] = ls; d[9] = p; d[16] = s; d[31] = w;
      return d;
   endfunction

   task automatic tick(); @(negedge clk); endtask

   task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic do_wr(input logic [31:0] d);
      wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic tmo(); lfps = 1'b1; tick(); lfps = 1'b0; endtask

   task automatic hrst(); host_rst = 1'b1; tick(); host_rst = 1'b0; endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      tick(); tick();
      chk("R1 link in reset", link, RX);
      chk("R1 pulse in reset", {3'b0, pulse}, 4'h0);
      rst_n = 1'b1; tick();

      // R4: attach / detach
      attach = 1'b1; tick(); chk("R4 to polling", link, PL);
      attach = 1'b0; tick(); chk("R4 detach", link, RX);

      // R2/R3/R5/R6 sweep in host mode
      for (int c = 0; c < 2; c++)
         for (int v = 0; v < 2; v++)
            for (int p = 0; p < 2; p++)
               for (int s = 0; s < 2; s++)
                  for (int a = 0; a < 2; a++) begin
                     logic ex;
                     host_mode = 1'b1; cap = c[0]; attach = 1'b0;
                     hrst();
                     attach = a[0];
                     do_wr(mk(v[0] ? 4'hA : 4'h3, p[0], s[0], 1'b0));
                     chk("R3 write keeps link", link, a[0] ? PL : RX);
                     attach = 1'b1;
                     if (a == 0) tick();
                     tmo();
                     ex = c[0] ? (v[0] && p[0] && s[0] && a == 0) : 1'b1;
                     chk(c[0] ? "R2 R5 armed entry" : "R6 free entry", link, ex ? CP : RX);
                     chk("R5 pulse", {3'b0, pulse}, {3'b0, ex});
                     tick();
                     chk("R5 pulse one cycle", {3'b0, pulse}, 4'h0);
                     attach = 1'b0;
                     do_wr(mk(4'h0, 1'b0, 1'b0, 1'b1));
                     chk("R8 warm to rxdet", link, RX);
                  end

      // R8: warm reset collides with a timeout
      cap = 1'b1; attach = 1'b0; hrst();
      do_wr(mk(4'hA, 1'b1, 1'b1, 1'b0));
      attach = 1'b1; tick();
      lfps = 1'b1; wr_en = 1'b1; wr_data = mk(4'h0, 1'b0, 1'b0, 1'b1); tick();
      lfps = 1'b0; wr_en = 1'b0; wr_data = '0;
      chk("R8 warm beats timeout link", link, RX);
      chk("R8 warm beats timeout pulse", {3'b0, pulse}, 4'h0);
      tick(); tmo();
      chk("R8 arm cleared", link, RX);

      // R8: arming fields and warm bit in one word
      attach = 1'b0; hrst();
      do_wr(mk(4'hA, 1'b1, 1'b1, 1'b1));
      attach = 1'b1; tick(); tmo();
      chk("R8 warm beats arm", link, RX);

      // R8: exit from Compliance needs re-arming
      attach = 1'b0; hrst();
      do_wr(mk(4'hA, 1'b1, 1'b1, 1'b0));
      attach = 1'b1; tick(); tmo();
      chk("R5 entry", link, CP);
      tick(); chk("R5 stays compliance", link, CP);
      do_wr(mk(4'h0, 1'b0, 1'b0, 1'b1));
      chk("R8 exit compliance", link, RX);
      tick(); tmo();
      chk("R8 re-arm needed", link, RX);

      // R9: host reset from Compliance
      attach = 1'b0; hrst();
      do_wr(mk(4'hA, 1'b1, 1'b1, 1'b0));
      attach = 1'b1; tick(); tmo();
      chk("R9 pre entry", link, CP);
      hrst(); chk("R9 host reset link", link, RX);
      tick(); tmo();
      chk("R9 arm cleared", link, RX);

      // R7: device mode, first failure only
      attach = 1'b0; rst_n = 1'b0; tick(); rst_n = 1'b1;
      host_mode = 1'b0; cap = 1'b1; tick();
      attach = 1'b1; tick(); tmo();
      chk("R7 first failure enters", link, CP);
      chk("R7 first pulse", {3'b0, pulse}, 4'h1);
      do_wr(mk(4'h0, 1'b0, 1'b0, 1'b1));
      tick(); tmo();
      chk("R7 second failure", link, RX);
      attach = 1'b0; tick();
      do_wr(mk(4'hA, 1'b1, 1'b1, 1'b0));
      attach = 1'b1; tick(); tmo();
      chk("R7 arm ignored", link, RX);
      cap = 1'b0; hrst(); tick(); tmo();
      chk("R7 host reset no restore", link, RX);

      finish_run();
   end
endmodule